// File: doc/BRIEF.md
# Double-Buffered Receive Length Tracker

This block tracks how many bytes of received data are waiting in a receive FIFO built from two buffer planes, and presents that count as a 12-bit read-only length field. On the write side, a packet-complete strobe with its byte count loads the count into the next free plane. On the read side, the block watches FIFO port reads of 1, 2 or 4 bytes, decides when the plane being read is drained, and then moves to the other plane. The FIFO storage itself is not part of the block. Only the lengths and full flags of the planes live here.

Two read-side modes decide what the field shows. In hold mode the field shows the whole packet length of the current plane until that plane is drained. With the hold-until-clear option set, the field instead keeps that length until a buffer-clear strobe arrives. In countdown mode the field falls by the width of every port read. It is shown through a fixed pipeline, so that each change appears a set number of clock cycles after the read that caused it. In double-buffer mode the planes are filled and read alternately. A plane that is full is never overwritten. In single-buffer mode only one plane is used.

Top module: `rxlt_len_tracker`

## Requirements
- R1: After reset the length field reads 0 and both planes are empty.
- R2: In hold mode (cnt_mode=0, hold_clr=0) the field shows the full length of the current plane and port reads do not change it. The read that drains the plane releases it, and the field then shows the next plane's length, or 0. Hold-mode changes are visible one cycle after the causing edge.
- R3: In hold mode with hold_clr=1 the field keeps the packet length after the plane is drained. Further port reads are ignored, and only buf_clr releases the plane.
- R4: In countdown mode (cnt_mode=1) each port read lowers the field by the access width given by rd_width: 1 byte for code 2'b00, 2 bytes for 2'b01 and 4 bytes for 2'b10.
- R5: rd_width code 2'b11 is reserved and counts as a 1-byte access.
- R6: In countdown mode a decrement below zero saturates at 0. A drained plane is always released, whatever the value of hold_clr.
- R7: In countdown mode a change caused by a port read sampled at clock edge N appears on the field at edge N+10 (parameter LAT), and not before.
- R8: In double-buffer mode (dbl_mode=1) packets fill the planes alternately. When the current plane is released while the other plane is full, the field switches to the other plane's length.
- R9: A packet that arrives while its target plane is full is dropped. The stored length of a full plane never changes until that plane is released.
- R10: buf_clr releases the current plane when it is full. The field then shows the other plane's length if that plane is full, or 0 if it is not. A buf_clr with no full plane has no effect.
- R11: In single-buffer mode (dbl_mode=0) only one plane is used, so a second packet that arrives before the first is released is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbl_mode | input | 1 | 1 = two planes used alternately, 0 = one plane |
| cnt_mode | input | 1 | 1 = countdown mode, 0 = hold mode |
| hold_clr | input | 1 | In hold mode, keep the length after drain until buf_clr |
| pkt_done | input | 1 | Write side: packet complete, load pkt_len into the next plane |
| pkt_len | input | 12 | Byte count of the completed packet |
| rd_stb | input | 1 | One FIFO port read this cycle |
| rd_width | input | 2 | Access width code: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = 1 byte |
| buf_clr | input | 1 | Release the current read plane |
| len_field | output | 12 | Reported receive length |

## Verification
Hold mode is tried with single-byte reads up to one short of the packet length and then with the final read. This separates "length held until drain" from "length counts down" and from "released early". Countdown mode uses every width code in turn on one packet, so that a wrong step for any code, a missing saturation or a wrong latency (the field is sampled one cycle before and at the tenth edge) shows up as a wrong value. Double-buffer patterns fill both planes, then push a third packet while both are full, then drain or clear. Together these tell correct plane switching apart from overwriting, from a wrong plane order and from a release that is dropped. Single-buffer and hold-until-clear patterns check that extra packets and extra reads are ignored.

// File: rtl/rxlt_pkg.sv
package rxlt_pkg;
   typedef enum logic [1:0] {
      ACC_B1  = 2'b00,
      ACC_B2  = 2'b01,
      ACC_B4  = 2'b10,
      ACC_RSV = 2'b11
   } acc_width_e;

   // Bytes moved by one port access; the reserved code counts as one byte.
   function automatic logic [2:0] step_bytes(input logic [1:0] code);
      case (acc_width_e'(code))
         ACC_B2:  step_bytes = 3'd2;
         ACC_B4:  step_bytes = 3'd4;
         default: step_bytes = 3'd1;
      endcase
   endfunction
endpackage

// File: rtl/rxlt_plane_bank.sv
module rxlt_plane_bank #(
   parameter int LEN_W = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      dbl_mode,
   input  logic                      wr_en,
   input  logic [LEN_W-1:0]          wr_len,
   input  logic                      rel_en,
   input  logic                      rel_plane,
   output logic [1:0]                full,
   output logic [1:0][LEN_W-1:0]     len
);
   localparam int NPL = 2;

   logic wr_sel_q;
   logic target;
   logic accept;

   assign target = dbl_mode ? wr_sel_q : 1'b0;
   assign accept = wr_en && !full[target];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wr_sel_q <= 1'b0;
      else if (accept && dbl_mode) wr_sel_q <= ~wr_sel_q;
   end

   for (genvar i = 0; i < NPL; i++) begin : g_plane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full[i] <= 1'b0;
            len[i]  <= '0;
         end else if (accept && (target == 1'(i))) begin
            full[i] <= 1'b1;
            len[i]  <= wr_len;
         end else if (rel_en && (rel_plane == 1'(i))) begin
            full[i] <= 1'b0;
         end
      end

      // A full plane keeps its length until it is released.
      assert_len_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (full[i] && !(rel_en && rel_plane == 1'(i))) |=> (full[i] && $stable(len[i])));
   end
endmodule

// File: rtl/rxlt_read_ctrl.sv
module rxlt_read_ctrl
   import rxlt_pkg::*;
#(
   parameter int LEN_W = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      dbl_mode,
   input  logic                      cnt_mode,
   input  logic                      hold_clr,
   input  logic                      rd_stb,
   input  logic [1:0]                rd_width,
   input  logic                      buf_clr,
   input  logic [1:0]                full,
   input  logic [1:0][LEN_W-1:0]     len,
   output logic                      rel_en,
   output logic                      rel_plane,
   output logic [LEN_W-1:0]          raw_len
);
   logic             rd_sel_q;
   logic             held_q;
   logic [LEN_W-1:0] cons_q;

   logic             cur_full;
   logic [LEN_W-1:0] cur_len;
   logic [LEN_W-1:0] rem;
   logic [LEN_W-1:0] step;
   logic [LEN_W-1:0] after;
   logic             rd_ok;
   logic             drain;
   logic             hold_keep;

   always_comb begin
      cur_full  = full[rd_sel_q];
      cur_len   = len[rd_sel_q];
      rem       = (cur_len > cons_q) ? (cur_len - cons_q) : '0;
      step      = LEN_W'(step_bytes(rd_width));
      after     = (rem > step) ? (rem - step) : '0;
      rd_ok     = rd_stb && cur_full && !held_q;
      drain     = rd_ok && (after == '0);
      hold_keep = hold_clr && !cnt_mode;
      rel_en    = cur_full && (buf_clr || (drain && !hold_keep));
      rel_plane = rd_sel_q;
      if (!cur_full)     raw_len = '0;
      else if (cnt_mode) raw_len = rem;
      else               raw_len = cur_len;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_sel_q <= 1'b0;
         held_q   <= 1'b0;
         cons_q   <= '0;
      end else if (rel_en) begin
         rd_sel_q <= dbl_mode ? ~rd_sel_q : 1'b0;
         held_q   <= 1'b0;
         cons_q   <= '0;
      end else if (drain && hold_keep) begin
         held_q   <= 1'b1;
      end else if (rd_ok) begin
         cons_q   <= cons_q + step;
      end
   end

   assert_sel_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rel_en |=> $stable(rd_sel_q));
   assert_held_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      held_q |-> full[rd_sel_q]);
   assert_rem_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      raw_len <= len[rd_sel_q]);
   assert_clr_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_clr && full[rd_sel_q]) |=> (!held_q && cons_q == '0));
endmodule

// File: rtl/rxlt_delay_line.sv
module rxlt_delay_line #(
   parameter int W      = 12,
   parameter int STAGES = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 0) begin : g_bad_depth
      $error("rxlt_delay_line: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_thru
      assign dout = din;
   end else begin : g_pipe
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[0] <= '0;
         else        stg[0] <= din;
      end
      for (genvar k = 1; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
      assign dout = stg[STAGES-1];
   end
endmodule

// File: rtl/rxlt_len_tracker.sv
module rxlt_len_tracker #(
   parameter int LEN_W = 12,
   parameter int LAT   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbl_mode,
   input  logic             cnt_mode,
   input  logic             hold_clr,
   input  logic             pkt_done,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             rd_stb,
   input  logic [1:0]       rd_width,
   input  logic             buf_clr,
   output logic [LEN_W-1:0] len_field
);
   if (LEN_W < 3) begin : g_bad_width
      $error("rxlt_len_tracker: LEN_W must hold a 4-byte step");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("rxlt_len_tracker: LAT must be at least 1");
   end

   logic [1:0]            full;
   logic [1:0][LEN_W-1:0] len;
   logic                  rel_en;
   logic                  rel_plane;
   logic [LEN_W-1:0]      raw_len;
   logic [LEN_W-1:0]      dly_len;

   rxlt_plane_bank #(.LEN_W(LEN_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode),
      .wr_en(pkt_done), .wr_len(pkt_len),
      .rel_en(rel_en), .rel_plane(rel_plane),
      .full(full), .len(len)
   );

   rxlt_read_ctrl #(.LEN_W(LEN_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .cnt_mode(cnt_mode),
      .hold_clr(hold_clr), .rd_stb(rd_stb), .rd_width(rd_width),
      .buf_clr(buf_clr), .full(full), .len(len),
      .rel_en(rel_en), .rel_plane(rel_plane), .raw_len(raw_len)
   );

   rxlt_delay_line #(.W(LEN_W), .STAGES(LAT)) u_dly (
      .clk(clk), .rst_n(rst_n), .din(raw_len), .dout(dly_len)
   );

   assign len_field = cnt_mode ? dly_len : raw_len;

   assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (full == 2'b00));
endmodule

// File: tb/tb_rxlt_len_tracker.sv
module tb_rxlt_len_tracker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbl_mode = 1'b0, cnt_mode = 1'b0, hold_clr = 1'b0;
   logic        pkt_done = 1'b0, rd_stb = 1'b0, buf_clr = 1'b0;
   logic [11:0] pkt_len = '0;
   logic [1:0]  rd_width = '0;
   logic [11:0] len_field;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rxlt_len_tracker dut (
      .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .cnt_mode(cnt_mode),
      .hold_clr(hold_clr), .pkt_done(pkt_done), .pkt_len(pkt_len),
      .rd_stb(rd_stb), .rd_width(rd_width), .buf_clr(buf_clr),
      .len_field(len_field)
   );

   task automatic tick(); @(posedge clk); @(negedge clk); endtask

   task automatic check(input string tag, input logic [11:0] exp);
      checks++;
      if (len_field !== exp) begin
         errors++;
         $display("FAIL %s: len_field=%0d expected=%0d", tag, len_field, exp);
      end
   endtask

   task automatic do_reset(input logic dbl, input logic cnt, input logic hc);
      rst_n = 1'b0; pkt_done = 0; rd_stb = 0; buf_clr = 0;
      dbl_mode = dbl; cnt_mode = cnt; hold_clr = hc;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic push(input int n);
      pkt_done = 1'b1; pkt_len = 12'(n); tick(); pkt_done = 1'b0;
   endtask

   task automatic rd(input logic [1:0] w);
      rd_stb = 1'b1; rd_width = w; tick(); rd_stb = 1'b0;
   endtask

   task automatic clr();
      buf_clr = 1'b1; tick(); buf_clr = 1'b0;
   endtask

   task automatic t_reset();
      do_reset(0, 0, 0);
      check("R1 reset value", 12'd0);
      rd(2'b00);
      check("R1 read with no plane full", 12'd0);
   endtask

   task automatic t_single_hold();
      do_reset(0, 0, 0);
      push(6);
      check("R2 hold shows full length", 12'd6);
      push(9);
      check("R11 second packet dropped in single mode", 12'd6);
      for (int i = 0; i < 5; i++) rd(2'b00);
      check("R2 field unchanged before drain", 12'd6);
      rd(2'b00);
      check("R2 drained plane released", 12'd0);
      push(2);
      check("R11 plane reusable after release", 12'd2);
   endtask

   task automatic t_hold_clear();
      do_reset(0, 0, 1);
      push(4);
      rd(2'b10);
      check("R3 length kept after drain", 12'd4);
      rd(2'b00);
      push(6);
      check("R3 reads and packets ignored while held", 12'd4);
      clr();
      check("R3 buf_clr releases held plane", 12'd0);
      push(6);
      check("R3 new packet after clear", 12'd6);
   endtask

   task automatic t_countdown();
      do_reset(0, 1, 0);
      push(10);
      repeat (12) tick();
      check("R4 countdown initial length", 12'd10);
      rd(2'b00);
      repeat (9) tick();
      check("R7 unchanged one cycle before latency", 12'd10);
      tick();
      check("R7 R4 1-byte step at latency", 12'd9);
      rd(2'b01); repeat (10) tick();
      check("R4 2-byte step", 12'd7);
      rd(2'b10); repeat (10) tick();
      check("R4 4-byte step", 12'd3);
      rd(2'b11); repeat (10) tick();
      check("R5 reserved code steps 1", 12'd2);
      hold_clr = 1'b1;
      rd(2'b10); repeat (10) tick();
      check("R6 saturates at zero", 12'd0);
      push(5); repeat (12) tick();
      check("R6 drained plane released despite hold_clr", 12'd5);
      hold_clr = 1'b0;
   endtask

   task automatic t_double_hold();
      do_reset(1, 0, 0);
      push(8); push(5);
      check("R8 first plane shown", 12'd8);
      rd(2'b10);
      check("R8 hold before drain", 12'd8);
      rd(2'b10);
      check("R8 switch to other plane", 12'd5);
      push(3);
      push(9);
      rd(2'b10); rd(2'b00);
      check("R8 third packet follows in order", 12'd3);
      rd(2'b01); rd(2'b00);
      check("R9 packet to full plane was dropped", 12'd0);
   endtask

   task automatic t_double_clear();
      do_reset(1, 0, 0);
      push(7); push(2);
      clr();
      check("R10 clear switches to full plane", 12'd2);
      clr();
      check("R10 clear with other empty", 12'd0);
      clr();
      check("R10 clear with nothing full", 12'd0);
      push(1);
      check("R10 write pointer intact after clears", 12'd1);
   endtask

   task automatic t_double_count();
      do_reset(1, 1, 0);
      push(4); push(6);
      repeat (12) tick();
      check("R8 countdown first plane", 12'd4);
      rd(2'b10); repeat (10) tick();
      check("R8 countdown switch to other plane", 12'd6);
      rd(2'b01); repeat (10) tick();
      check("R4 countdown on second plane", 12'd4);
   endtask

   initial begin
      t_reset();
      t_single_hold();
      t_hold_clear();
      t_countdown();
      t_double_hold();
      t_double_clear();
      t_double_count();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule